// File: doc/BRIEF.md
# Chained Descriptor DMA Channel

This block is one direction of a DMA engine. Software lays out a linked list of descriptors in memory and then writes the address of the first one into the head register. The engine fetches each descriptor over a single request/acknowledge memory port. It reads the buffer that the descriptor points at, one 32-bit word at a time, and presents every word on an output stream. It then writes the descriptor's status word back, with the hardware-owned flag cleared and the moved byte count filled in. Finally it publishes the descriptor's address in a completion register and raises a completion event.

When a descriptor has a null link, the engine marks it as the last in the queue and goes idle. Software restarts the channel by writing the head register again. Software can also abort the channel with a teardown command. The abort is reported with a reserved completion value and a flag in the descriptor that was in flight. A self-clearing soft reset returns the engine and its registers to the power-on state.

Register offsets on `reg_addr`: 0 control (bit 0 enables the channel), 1 soft reset, 2 teardown, 3 head pointer, 4 completion pointer. Reads are combinational on `reg_addr`. Addresses are byte addresses and are word aligned.

Top module: `chain_dma_channel`

## Requirements
- R1: A descriptor is four words at its address: +0 link to the next descriptor, +4 buffer address, +8 buffer length in bytes (low 11 bits), +12 status word. The engine fetches them in that order.
- R2: Writing a nonzero address to the head register starts processing there, but only while the channel is enabled and idle. A write of zero, or a write while the channel is disabled, issues no memory request.
- R3: For a length of L bytes, the engine reads ceil(L/4) consecutive words from the buffer address and presents each word on the stream in address order. A zero length moves nothing.
- R4: The written-back status word has bit 29 (owned by hardware) cleared and bits 10:0 set to the number of bytes moved. Bits 31, 30 and 26 are kept as fetched.
- R5: When the link word is zero, bit 28 (end of queue) is set in the written-back status. The engine then stops and the head register reads 0. A later head write starts the engine again.
- R6: On each completion the completion register takes the descriptor address and `done_evt` rises. `done_evt` stays high until software writes that same value to the completion register. A write of any other value leaves it high.
- R7: A descriptor fetched with bit 29 already clear is skipped. It gets no write-back and produces no stream data, `err_evt` pulses for one cycle, and the engine follows its link.
- R8: Writing 1 to the teardown register stops the engine at the next word boundary. The in-flight descriptor's status is written with bit 27 set, bit 29 clear and the bytes moved so far. The completion register then reads 0xFFFFFFFC and `done_evt` rises. If the engine is idle, only the completion register and event change.
- R9: After `rst_n`, every register reads 0. Writing 1 to the soft-reset register makes it read 1 until the memory port is quiet and RST_CYCLES have passed. It then reads 0, and control, head, completion and `done_evt` are all 0.
- R10: A memory request holds its address, direction and write data steady until it is acknowledged, and only one request is outstanding at a time.
- R11: Clearing the enable bit during a chain lets the current descriptor finish. The engine then stops, with the head register holding the next link. Writing that address to the head register resumes the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for write and read |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory acknowledge, returns read data |
| mem_rdata | input | 32 | Memory read data |
| st_valid | output | 1 | Stream word valid |
| st_data | output | 32 | Stream word |
| done_evt | output | 1 | Completion event, held until acknowledged |
| err_evt | output | 1 | One-cycle pulse on a skipped descriptor |

## Verification
The bench sweeps buffer lengths 0 to 9 bytes, which covers the rounding of partial words and the zero-length case. A wrong word count would show as a short or long stream, or as a wrong length field in the status word. It runs a chain with an unowned middle descriptor: a design that copied that descriptor or wrote it back would corrupt its status, and one that stopped there would leave the last completion missing. It aborts a long transfer with a teardown and checks that the reported length matches the words actually streamed. It also checks that an acknowledge with the wrong value keeps the event high, and that a soft reset issued mid-transfer leaves no register or event set.

// File: rtl/chain_dma_pkg.sv
package chain_dma_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_FETCH = 2'd1,
    WK_COPY  = 2'd2,
    WK_WBACK = 2'd3
  } walk_state_e;

  localparam int          ST_SOP   = 31;
  localparam int          ST_EOP   = 30;
  localparam int          ST_OWN   = 29;
  localparam int          ST_EOQ   = 28;
  localparam int          ST_TDONE = 27;
  localparam int          ST_CRC   = 26;
  localparam logic [31:0] TD_MARK  = 32'hFFFF_FFFC;

  localparam logic [2:0]  RA_CTRL  = 3'd0;
  localparam logic [2:0]  RA_SRST  = 3'd1;
  localparam logic [2:0]  RA_TDOWN = 3'd2;
  localparam logic [2:0]  RA_HEAD  = 3'd3;
  localparam logic [2:0]  RA_CMPL  = 3'd4;
endpackage

// File: rtl/chain_dma_regs.sv
module chain_dma_regs
  import chain_dma_pkg::*;
#(
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cmpl_valid,
  input  logic [31:0] cmpl_addr,
  input  logic [31:0] cur_ptr,
  input  logic        walker_idle,
  output logic        enable,
  output logic        start,
  output logic [31:0] start_addr,
  output logic        td_req,
  output logic        abort,
  output logic        done_evt
);
  localparam int RC_W = $clog2(RST_CYCLES) + 1;

  logic            en_q, en_d;
  logic            srst_q, srst_d;
  logic [RC_W-1:0] rcnt_q, rcnt_d;
  logic [31:0]     cp_q, cp_d;
  logic            done_q, done_d;
  logic            srst_done;
  logic            wr_ok, wr_cmpl;

  assign wr_ok     = reg_wr && !srst_q;
  assign wr_cmpl   = wr_ok && (reg_addr == RA_CMPL);
  assign srst_done = srst_q && walker_idle && (rcnt_q == RC_W'(RST_CYCLES - 1));

  always_comb begin
    en_d   = en_q;
    srst_d = srst_q;
    rcnt_d = rcnt_q;
    cp_d   = cp_q;
    done_d = done_q;
    if (wr_ok && reg_addr == RA_CTRL) en_d = reg_wdata[0];
    if (wr_ok && reg_addr == RA_SRST && reg_wdata[0]) srst_d = 1'b1;
    if (srst_q && walker_idle) rcnt_d = rcnt_q + RC_W'(1);
    if (cmpl_valid) begin
      cp_d   = cmpl_addr;
      done_d = 1'b1;
    end else if (wr_cmpl && reg_wdata == cp_q) begin
      done_d = 1'b0;
    end
    if (srst_done) begin
      en_d   = 1'b0;
      srst_d = 1'b0;
      rcnt_d = '0;
      cp_d   = '0;
      done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      srst_q <= 1'b0;
      rcnt_q <= '0;
      cp_q   <= '0;
      done_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      srst_q <= srst_d;
      rcnt_q <= rcnt_d;
      cp_q   <= cp_d;
      done_q <= done_d;
    end
  end

  assign enable     = en_q;
  assign abort      = srst_q;
  assign done_evt   = done_q;
  assign start      = wr_ok && (reg_addr == RA_HEAD) && (reg_wdata != 32'd0);
  assign start_addr = reg_wdata;
  assign td_req     = wr_ok && (reg_addr == RA_TDOWN) && reg_wdata[0];

  always_comb begin
    case (reg_addr)
      RA_CTRL: reg_rdata = {31'd0, en_q};
      RA_SRST: reg_rdata = {31'd0, srst_q};
      RA_HEAD: reg_rdata = cur_ptr;
      RA_CMPL: reg_rdata = cp_q;
      default: reg_rdata = 32'd0;
    endcase
  end

  // R9: leaving soft reset leaves every register cleared
  assert_srst_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(srst_q) |-> (!en_q && !done_q && cp_q == 32'd0));

  // R6: the event only rises after a completion reported by the walker
  assert_done_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_q) |-> $past(cmpl_valid));
endmodule

// File: rtl/chain_dma_walker.sv
module chain_dma_walker
  import chain_dma_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        start,
  input  logic [31:0] start_addr,
  input  logic        td_req,
  input  logic        abort,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  output logic [31:0] st_data,
  output logic        cmpl_valid,
  output logic [31:0] cmpl_addr,
  output logic        err_evt,
  output logic        idle,
  output logic [31:0] cur_ptr
);
  localparam int CNT_W = LEN_W - 1;

  walk_state_e      st_q, st_d;
  logic [31:0]      cur_q, cur_d;
  logic [31:0]      nxt_q, nxt_d;
  logic [31:0]      buf_q, buf_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [31:0]      mode_q, mode_d;
  logic [1:0]       fidx_q, fidx_d;
  logic [CNT_W-1:0] wcnt_q, wcnt_d;
  logic             td_q, td_d;
  logic             tdhit_q, tdhit_d;
  logic             stv_q, stv_d;
  logic [31:0]      std_q, std_d;
  logic             err_q, err_d;

  logic [LEN_W:0]   len_p3;
  logic [CNT_W-1:0] words_tot;
  logic [LEN_W:0]   bytes_done;
  logic [LEN_W-1:0] xfer_len;
  logic [31:0]      wb_mode;
  logic             td_now;

  assign len_p3     = {1'b0, len_q} + (LEN_W + 1)'(3);
  assign words_tot  = len_p3[LEN_W:2];
  assign bytes_done = {wcnt_q, 2'b00};
  assign xfer_len   = (bytes_done > {1'b0, len_q}) ? len_q : bytes_done[LEN_W-1:0];
  assign td_now     = td_q | td_req;

  always_comb begin
    wb_mode                = mode_q;
    wb_mode[ST_OWN]        = 1'b0;
    wb_mode[LEN_W-1:0]     = xfer_len;
    if (nxt_q == 32'd0) wb_mode[ST_EOQ] = 1'b1;
    if (tdhit_q)        wb_mode[ST_TDONE] = 1'b1;
  end

  assign mem_req   = (st_q != WK_IDLE);
  assign mem_we    = (st_q == WK_WBACK);
  assign mem_wdata = wb_mode;

  always_comb begin
    case (st_q)
      WK_FETCH: mem_addr = cur_q + 32'({fidx_q, 2'b00});
      WK_COPY:  mem_addr = buf_q + 32'({wcnt_q, 2'b00});
      WK_WBACK: mem_addr = cur_q + 32'd12;
      default:  mem_addr = cur_q;
    endcase
  end

  always_comb begin
    st_d       = st_q;
    cur_d      = cur_q;
    nxt_d      = nxt_q;
    buf_d      = buf_q;
    len_d      = len_q;
    mode_d     = mode_q;
    fidx_d     = fidx_q;
    wcnt_d     = wcnt_q;
    td_d       = td_now;
    tdhit_d    = tdhit_q;
    stv_d      = 1'b0;
    std_d      = std_q;
    err_d      = 1'b0;
    cmpl_valid = 1'b0;
    cmpl_addr  = cur_q;
    case (st_q)
      WK_IDLE: begin
        if (abort) begin
          cur_d = 32'd0;
          td_d  = 1'b0;
        end else if (td_now) begin
          cmpl_valid = 1'b1;
          cmpl_addr  = TD_MARK;
          td_d       = 1'b0;
          cur_d      = 32'd0;
        end else if (start && enable) begin
          cur_d  = start_addr;
          fidx_d = 2'd0;
          st_d   = WK_FETCH;
        end
      end
      WK_FETCH: begin
        if (mem_ack) begin
          if (abort) begin
            st_d  = WK_IDLE;
            cur_d = 32'd0;
            td_d  = 1'b0;
          end else begin
            fidx_d = fidx_q + 2'd1;
            case (fidx_q)
              2'd0:    nxt_d  = mem_rdata;
              2'd1:    buf_d  = mem_rdata;
              2'd2:    len_d  = mem_rdata[LEN_W-1:0];
              default: mode_d = mem_rdata;
            endcase
            if (fidx_q == 2'd3) begin
              wcnt_d  = '0;
              tdhit_d = 1'b0;
              if (!mem_rdata[ST_OWN]) begin
                err_d = 1'b1;
                if (td_now) begin
                  cmpl_valid = 1'b1;
                  cmpl_addr  = TD_MARK;
                  td_d       = 1'b0;
                  st_d       = WK_IDLE;
                  cur_d      = 32'd0;
                end else if (nxt_q == 32'd0) begin
                  st_d  = WK_IDLE;
                  cur_d = 32'd0;
                end else if (enable) begin
                  cur_d  = nxt_q;
                  fidx_d = 2'd0;
                end else begin
                  st_d  = WK_IDLE;
                  cur_d = nxt_q;
                end
              end else if (td_now) begin
                tdhit_d = 1'b1;
                st_d    = WK_WBACK;
              end else if (words_tot == '0) begin
                st_d = WK_WBACK;
              end else begin
                st_d = WK_COPY;
              end
            end
          end
        end
      end
      WK_COPY: begin
        if (mem_ack) begin
          if (abort) begin
            st_d  = WK_IDLE;
            cur_d = 32'd0;
            td_d  = 1'b0;
          end else begin
            stv_d  = 1'b1;
            std_d  = mem_rdata;
            wcnt_d = wcnt_q + CNT_W'(1);
            if (td_now) begin
              tdhit_d = 1'b1;
              st_d    = WK_WBACK;
            end else if (wcnt_q + CNT_W'(1) == words_tot) begin
              st_d = WK_WBACK;
            end
          end
        end
      end
      default: begin
        if (mem_ack) begin
          st_d = WK_IDLE;
          if (abort) begin
            cur_d = 32'd0;
            td_d  = 1'b0;
          end else if (tdhit_q) begin
            cmpl_valid = 1'b1;
            cmpl_addr  = TD_MARK;
            td_d       = 1'b0;
            tdhit_d    = 1'b0;
            cur_d      = 32'd0;
          end else begin
            cmpl_valid = 1'b1;
            cmpl_addr  = cur_q;
            if (nxt_q == 32'd0) begin
              cur_d = 32'd0;
            end else begin
              cur_d = nxt_q;
              if (enable && !td_now) begin
                fidx_d = 2'd0;
                st_d   = WK_FETCH;
              end
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WK_IDLE;
      cur_q   <= '0;
      nxt_q   <= '0;
      buf_q   <= '0;
      len_q   <= '0;
      mode_q  <= '0;
      fidx_q  <= '0;
      wcnt_q  <= '0;
      td_q    <= 1'b0;
      tdhit_q <= 1'b0;
      stv_q   <= 1'b0;
      std_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      nxt_q   <= nxt_d;
      buf_q   <= buf_d;
      len_q   <= len_d;
      mode_q  <= mode_d;
      fidx_q  <= fidx_d;
      wcnt_q  <= wcnt_d;
      td_q    <= td_d;
      tdhit_q <= tdhit_d;
      stv_q   <= stv_d;
      std_q   <= std_d;
      err_q   <= err_d;
    end
  end

  assign st_valid = stv_q;
  assign st_data  = std_q;
  assign err_evt  = err_q;
  assign idle     = (st_q == WK_IDLE);
  assign cur_ptr  = cur_q;

  // R10: an unanswered request keeps its address, direction and data
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  // R4: every status write-back hands the descriptor to software
  assert_wb_owner_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> !mem_wdata[ST_OWN]);

  // R7: a skip pulse is never followed by stream data from that descriptor
  assert_skip_no_stream_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> !stv_q);
endmodule

// File: rtl/chain_dma_channel.sv
module chain_dma_channel
  import chain_dma_pkg::*;
#(
  parameter int LEN_W      = 11,
  parameter int RST_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [2:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  output logic        st_valid,
  output logic [31:0] st_data,
  output logic        done_evt,
  output logic        err_evt
);
  logic        enable, start, td_req, abort;
  logic [31:0] start_addr, cmpl_addr, cur_ptr;
  logic        cmpl_valid, walker_idle;

  chain_dma_regs #(.RST_CYCLES(RST_CYCLES)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_wr     (reg_wr),
    .reg_addr   (reg_addr),
    .reg_wdata  (reg_wdata),
    .reg_rdata  (reg_rdata),
    .cmpl_valid (cmpl_valid),
    .cmpl_addr  (cmpl_addr),
    .cur_ptr    (cur_ptr),
    .walker_idle(walker_idle),
    .enable     (enable),
    .start      (start),
    .start_addr (start_addr),
    .td_req     (td_req),
    .abort      (abort),
    .done_evt   (done_evt)
  );

  chain_dma_walker #(.LEN_W(LEN_W)) u_walker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .start      (start),
    .start_addr (start_addr),
    .td_req     (td_req),
    .abort      (abort),
    .mem_req    (mem_req),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .mem_wdata  (mem_wdata),
    .mem_ack    (mem_ack),
    .mem_rdata  (mem_rdata),
    .st_valid   (st_valid),
    .st_data    (st_data),
    .cmpl_valid (cmpl_valid),
    .cmpl_addr  (cmpl_addr),
    .err_evt    (err_evt),
    .idle       (walker_idle),
    .cur_ptr    (cur_ptr)
  );
endmodule

// File: tb/chain_dma_channel_bench.sv
module chain_dma_channel_bench;
  localparam logic [31:0] B_SOP = 32'h8000_0000;
  localparam logic [31:0] B_EOP = 32'h4000_0000;
  localparam logic [31:0] B_OWN = 32'h2000_0000;
  localparam logic [31:0] B_EOQ = 32'h1000_0000;
  localparam logic [31:0] B_TDC = 32'h0800_0000;
  localparam logic [31:0] B_CRC = 32'h0400_0000;
  localparam logic [31:0] TDV   = 32'hFFFF_FFFC;

  logic        clk, rst_n;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        mem_req, mem_we, mem_ack;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic        st_valid, done_evt, err_evt;
  logic [31:0] st_data;

  logic        tb_we;
  logic [9:0]  tb_wa;
  logic [31:0] tb_wd;
  logic [31:0] mem [0:1023];
  logic [31:0] sbuf [0:1023];
  int          scnt, ecnt, rcnt;
  int          nchk, nfail;
  logic        finished;

  chain_dma_channel u_chain_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .st_valid(st_valid),
    .st_data(st_data), .done_evt(done_evt), .err_evt(err_evt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always @(posedge clk) begin
    if (tb_we) mem[tb_wa] <= tb_wd;
    if (!rst_n) begin
      mem_ack <= 1'b0;
      scnt <= 0; ecnt <= 0; rcnt <= 0;
    end else begin
      if (mem_req && !mem_ack) begin
        mem_ack   <= 1'b1;
        mem_rdata <= mem[mem_addr[11:2]];
        rcnt      <= rcnt + 1;
        if (mem_we) mem[mem_addr[11:2]] <= mem_wdata;
      end else begin
        mem_ack <= 1'b0;
      end
      if (st_valid) begin
        sbuf[scnt[9:0]] <= st_data;
        scnt <= scnt + 1;
      end
      if (err_evt) ecnt <= ecnt + 1;
    end
  end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A5A, ~a[15:0]};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wmem(input logic [31:0] a, input logic [31:0] d);
    @(negedge clk);
    tb_we = 1'b1; tb_wa = a[11:2]; tb_wd = d;
    @(negedge clk);
    tb_we = 1'b0;
  endtask

  task automatic wreg(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic mkdesc(input logic [31:0] a, input logic [31:0] nx, input logic [31:0] bf,
                        input logic [31:0] ln, input logic [31:0] md);
    wmem(a, nx); wmem(a + 4, bf); wmem(a + 8, ln); wmem(a + 12, md);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_evt && n < 5000) begin @(negedge clk); n++; end
    check(req, {31'd0, done_evt}, 32'd1);
  endtask

  task automatic wait_head_zero(input string req);
    logic [31:0] v;
    int n = 0;
    rreg(3'd3, v);
    while (v != 32'd0 && n < 5000) begin rreg(3'd3, v); n++; end
    check(req, v, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", nchk + 1, nfail + 1);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int base, eb, rb, words, ntd;
    finished = 1'b0; nchk = 0; nfail = 0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 32'd0;
    tb_we = 1'b0; tb_wa = '0; tb_wd = '0;
    for (int i = 0; i < 1024; i++) wmem(32'(i * 4), pat(32'(i * 4)));
    @(negedge clk); rst_n = 1'b1;

    // R9: reset state
    for (int a = 0; a < 5; a++) begin
      rreg(3'(a), v);
      check("R9 reset reg", v, 32'd0);
    end
    check("R9 reset done", {31'd0, done_evt}, 32'd0);

    // R2: head write while disabled is ignored
    mkdesc(32'h100, 32'd0, 32'h400, 32'd4, B_OWN | B_SOP | B_EOP | 32'd4);
    rb = rcnt;
    wreg(3'd3, 32'h100);
    repeat (20) @(negedge clk);
    check("R2 disabled no request", 32'(rcnt - rb), 32'd0);
    rreg(3'd3, v);
    check("R2 disabled head", v, 32'd0);
    wreg(3'd0, 32'd1);
    rreg(3'd0, v);
    check("R2 enable reads back", v, 32'd1);
    wreg(3'd3, 32'd0);
    repeat (20) @(negedge clk);
    check("R2 zero head no request", 32'(rcnt - rb), 32'd0);

    // R1 R3 R4 R5 R6: length sweep over single descriptors
    for (int L = 0; L < 10; L++) begin
      logic [31:0] bf, md;
      bf = 32'h400 + 32'(L * 64);
      md = B_OWN | B_SOP | B_EOP | B_CRC | 32'(L);
      mkdesc(32'h100, 32'd0, bf, 32'(L), md);
      base = scnt;
      wreg(3'd3, 32'h100);
      wait_done("R6 single done");
      words = (L + 3) / 4;
      check("R3 stream count", 32'(scnt - base), 32'(words));
      for (int w = 0; w < words; w++)
        check("R3 stream word", sbuf[base + w], pat(bf + 32'(4 * w)));
      check("R4 R5 status", mem[32'h10C >> 2], B_SOP | B_EOP | B_CRC | B_EOQ | 32'(L));
      rreg(3'd4, v);
      check("R6 completion ptr", v, 32'h100);
      rreg(3'd3, v);
      check("R5 head zero", v, 32'd0);
      wreg(3'd4, 32'h104);
      check("R6 wrong ack holds", {31'd0, done_evt}, 32'd1);
      wreg(3'd4, 32'h100);
      check("R6 ack clears", {31'd0, done_evt}, 32'd0);
    end

    // R7: chain with an unowned middle descriptor
    mkdesc(32'h100, 32'h140, 32'h600, 32'd8, B_OWN | B_SOP | B_EOP | 32'd8);
    mkdesc(32'h140, 32'h180, 32'h680, 32'd4, B_SOP | B_EOP | 32'd4);
    mkdesc(32'h180, 32'd0,   32'h700, 32'd12, B_OWN | B_SOP | B_EOP | 32'd12);
    base = scnt; eb = ecnt;
    wreg(3'd3, 32'h100);
    wait_head_zero("R7 chain ends");
    check("R7 err pulses", 32'(ecnt - eb), 32'd1);
    check("R7 stream count", 32'(scnt - base), 32'd5);
    check("R7 stream first", sbuf[base], pat(32'h600));
    check("R7 stream after skip", sbuf[base + 2], pat(32'h700));
    check("R7 skipped untouched", mem[32'h14C >> 2], B_SOP | B_EOP | 32'd4);
    check("R5 mid no eoq", mem[32'h10C >> 2], B_SOP | B_EOP | 32'd8);
    check("R5 last eoq", mem[32'h18C >> 2], B_SOP | B_EOP | B_EOQ | 32'd12);
    rreg(3'd4, v);
    check("R6 last completion", v, 32'h180);
    wreg(3'd4, 32'h180);

    // R8: teardown in the middle of a long copy
    mkdesc(32'h200, 32'd0, 32'h800, 32'd400, B_OWN | B_SOP | B_EOP | 32'd400);
    base = scnt;
    wreg(3'd3, 32'h200);
    repeat (40) @(negedge clk);
    wreg(3'd2, 32'd1);
    wait_done("R8 teardown done");
    ntd = scnt - base;
    rreg(3'd4, v);
    check("R8 teardown ptr", v, TDV);
    check("R8 partial", {31'd0, (ntd > 0 && ntd < 100)}, 32'd1);
    check("R8 status", mem[32'h20C >> 2], B_SOP | B_EOP | B_EOQ | B_TDC | 32'(ntd * 4));
    rreg(3'd3, v);
    check("R8 head cleared", v, 32'd0);
    wreg(3'd4, TDV);
    check("R8 ack", {31'd0, done_evt}, 32'd0);

    // R8: teardown while idle
    wreg(3'd2, 32'd1);
    wait_done("R8 idle teardown");
    rreg(3'd4, v);
    check("R8 idle ptr", v, TDV);
    wreg(3'd4, TDV);

    // R11: disable mid chain, then resume
    mkdesc(32'h100, 32'h140, 32'h400, 32'd4, B_OWN | B_SOP | B_EOP | 32'd4);
    mkdesc(32'h140, 32'd0,   32'h480, 32'd4, B_OWN | B_SOP | B_EOP | 32'd4);
    wreg(3'd3, 32'h100);
    wreg(3'd0, 32'd0);
    wait_done("R11 first done");
    repeat (10) @(negedge clk);
    rreg(3'd4, v);
    check("R11 first ptr", v, 32'h100);
    rreg(3'd3, v);
    check("R11 head holds link", v, 32'h140);
    check("R11 second still owned", mem[32'h14C >> 2], B_OWN | B_SOP | B_EOP | 32'd4);
    wreg(3'd4, 32'h100);
    wreg(3'd0, 32'd1);
    wreg(3'd3, 32'h140);
    wait_done("R11 resume done");
    rreg(3'd4, v);
    check("R11 resume ptr", v, 32'h140);
    wreg(3'd4, 32'h140);

    // R9: soft reset in the middle of a transfer
    mkdesc(32'h200, 32'd0, 32'h800, 32'd400, B_OWN | B_SOP | B_EOP | 32'd400);
    wreg(3'd3, 32'h200);
    repeat (30) @(negedge clk);
    wreg(3'd1, 32'd1);
    rreg(3'd1, v);
    check("R9 srst busy", v, 32'd1);
    repeat (40) @(negedge clk);
    rreg(3'd1, v);
    check("R9 srst self clears", v, 32'd0);
    rreg(3'd0, v);
    check("R9 ctrl cleared", v, 32'd0);
    rreg(3'd3, v);
    check("R9 head cleared", v, 32'd0);
    rreg(3'd4, v);
    check("R9 cmpl cleared", v, 32'd0);
    check("R9 done cleared", {31'd0, done_evt}, 32'd0);
    rb = rcnt;
    repeat (20) @(negedge clk);
    check("R10 R9 port quiet", 32'(rcnt - rb), 32'd0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule